// File: doc/BRIEF.md
# Integer Comparison Unit

This block decides how two integer register operands relate to each other, for a 32-bit load/store style datapath. It forms the difference of operand A minus operand B. From that difference it derives equality with a zero detector and ordering with a sign bit. A select code picks one relation, either signed or unsigned. The answer comes out in two forms: a single condition bit that branch logic can use, and a full-width word holding exactly 0 or 1 that can be written back as a set-on-condition result.

The block has no clock and keeps no stored flags. Both operands are widened by one bit before the subtraction: sign extension for signed relations and zero extension for unsigned ones. Because of this, bit 32 of the 33-bit difference always gives the true ordering, and no separate overflow term is needed. The register file, instruction decode and pipelining belong to the surrounding datapath.

Top module: `cmp_unit`

## Requirements
- R1: `sel_i[3]` picks the number system: 0 means signed, where both operands are sign-extended to 33 bits; 1 means unsigned, where both are zero-extended. `sel_i[2:0]` picks the relation.
- R2: Relation code 0 (equal) is true exactly when every bit of the 33-bit difference A-B is zero, which is exactly when `opa_i == opb_i`.
- R3: Relation code 2 (less than), signed, is true exactly when A < B as two's complement numbers. This includes operand pairs whose 32-bit difference overflows, such as 0x80000000 against 0x00000001.
- R4: Relation code 2, unsigned, is true exactly when A < B as unsigned numbers. The result is taken from bit 32 of the zero-extended difference.
- R5: Relation code 4 (less or equal) is true exactly when the difference is negative or zero, in the chosen number system.
- R6: Relation code 5 (greater than) is true exactly when the difference is neither zero nor negative, in the chosen number system.
- R7: Relation code 1 (not equal) is the inverse of code 0. Relation code 3 (greater or equal) is the inverse of code 2 in the same number system.
- R8: Relation codes 6 and 7 give a false condition whatever the operands are.
- R9: `set_word_o` has bits 31 to 1 at zero, and its bit 0 equals `cond_o`.
- R10: The outputs depend only on the present inputs. No clock and no stored state are involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | Operand A (minuend) |
| opb_i | input | 32 | Operand B (subtrahend) |
| sel_i | input | 4 | Bit 3: unsigned mode; bits 2:0: relation code |
| cond_o | output | 1 | Selected condition, for branch logic |
| set_word_o | output | 32 | Selected condition as a 0/1 integer word |

## Verification
The zero detector and the sign bit both read the same difference in the same evaluation. Every select code therefore depends on how those two indications combine. Equal operand pairs, neighbouring values and signed-overflow pairs (the most negative value against 1, the most positive against all ones) are driven under every select code, so that zero and sign must each settle correctly together. Every result is judged against a reference built from native signed and unsigned comparison operators rather than from subtraction. Seeded random operands fill in the remaining space.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  localparam int unsigned SEL_W = 4;
  localparam int unsigned REL_W = 3;

  typedef enum logic [REL_W-1:0] {
    REL_EQ = 3'd0,
    REL_NE = 3'd1,
    REL_LT = 3'd2,
    REL_GE = 3'd3,
    REL_LE = 3'd4,
    REL_GT = 3'd5,
    REL_R6 = 3'd6,
    REL_R7 = 3'd7
  } cmp_rel_e;

  // Resolve one relation from the zero and negative indications.
  function automatic logic rel_resolve(input cmp_rel_e rel, input logic is_zero,
                                       input logic is_neg);
    logic res;
    case (rel)
      REL_EQ:  res = is_zero;
      REL_NE:  res = ~is_zero;
      REL_LT:  res = is_neg;
      REL_GE:  res = ~is_neg;
      REL_LE:  res = is_neg | is_zero;
      REL_GT:  res = ~is_neg & ~is_zero;
      default: res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cmp_widen.sv
module cmp_widen #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         sext_i,
  output logic [W:0]   wide_o
);
  // Extension bit: copy of the sign in signed mode, zero otherwise.
  assign wide_o = {sext_i & val_i[W-1], val_i};
endmodule

// File: rtl/cmp_diff.sv
module cmp_diff #(
  parameter int unsigned W  = 32,
  localparam int unsigned XW = W + 1
) (
  input  logic [XW-1:0] a_i,
  input  logic [XW-1:0] b_i,
  output logic [XW-1:0] diff_o,
  output logic          zero_o,
  output logic          neg_o
);
  function automatic logic [XW-1:0] sub_wide(input logic [XW-1:0] x,
                                             input logic [XW-1:0] y);
    return x + ~y + {{(XW-1){1'b0}}, 1'b1};
  endfunction

  assign diff_o = sub_wide(a_i, b_i);
  assign zero_o = ~|diff_o;
  assign neg_o  = diff_o[XW-1];
endmodule

// File: rtl/cmp_cond.sv
module cmp_cond
  import cmp_pkg::*;
(
  input  cmp_rel_e rel_i,
  input  logic     zero_i,
  input  logic     neg_i,
  output logic     cond_o
);
  always_comb begin
    cond_o = rel_resolve(rel_i, zero_i, neg_i);
  end
endmodule

// File: rtl/cmp_unit.sv
module cmp_unit
  import cmp_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned XW = W + 1
) (
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             cond_o,
  output logic [W-1:0]     set_word_o
);
  logic          mode_unsigned;
  cmp_rel_e      rel;
  logic [W-1:0]  ops  [2];
  logic [XW-1:0] wide [2];
  logic [XW-1:0] diff;
  logic          diff_zero;
  logic          diff_neg;

  assign mode_unsigned = sel_i[SEL_W-1];
  assign rel           = cmp_rel_e'(sel_i[REL_W-1:0]);
  assign ops[0]        = opa_i;
  assign ops[1]        = opb_i;

  for (genvar g = 0; g < 2; g++) begin : g_widen
    cmp_widen #(.W(W)) u_widen (
      .val_i (ops[g]),
      .sext_i(~mode_unsigned),
      .wide_o(wide[g])
    );
  end

  cmp_diff #(.W(W)) u_diff (
    .a_i   (wide[0]),
    .b_i   (wide[1]),
    .diff_o(diff),
    .zero_o(diff_zero),
    .neg_o (diff_neg)
  );

  cmp_cond u_cond (
    .rel_i (rel),
    .zero_i(diff_zero),
    .neg_i (diff_neg),
    .cond_o(cond_o)
  );

  assign set_word_o = {{(W-1){1'b0}}, cond_o};
endmodule

// File: rtl/cmp_unit_chk.sv
module cmp_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [3:0]   sel_i,
  input logic         cond_o,
  input logic [W-1:0] set_word_o,
  input logic         diff_zero,
  input logic         diff_neg
);
  always_comb begin
    AST_ZERO_MEANS_EQUAL: assert (diff_zero == (opa_i == opb_i)); // R2
    AST_ZERO_NOT_NEG: assert (!(diff_zero && diff_neg)); // R6
    if (sel_i == 4'h2) begin
      AST_SIGNED_ORDER: assert (cond_o == ($signed(opa_i) < $signed(opb_i))); // R3
    end
    if (sel_i == 4'hA) begin
      AST_UNSIGNED_ORDER: assert (cond_o == (opa_i < opb_i)); // R4
    end
    if (sel_i[2:1] == 2'b11) begin
      AST_SPARE_CODES_FALSE: assert (!cond_o); // R8
    end
    AST_WORD_UPPER_ZERO: assert (set_word_o[W-1:1] == '0); // R9
    AST_WORD_BIT0_COND: assert (set_word_o[0] == cond_o); // R9
  end
endmodule

bind cmp_unit cmp_unit_chk #(.W(W)) u_chk (
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .sel_i     (sel_i),
  .cond_o    (cond_o),
  .set_word_o(set_word_o),
  .diff_zero (diff_zero),
  .diff_neg  (diff_neg)
);

// File: tb/tb_cmp_unit.sv
module tb_cmp_unit;
  localparam int unsigned W = 32;
  localparam int unsigned NRAND = 1500;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opa, opb;
  logic [3:0]   sel;
  logic         cond;
  logic [W-1:0] word;
  int           checks = 0;
  int           errors = 0;
  logic         done = 1'b0;

  always #10 clk = ~clk;

  cmp_unit dut (
    .opa_i     (opa),
    .opb_i     (opb),
    .sel_i     (sel),
    .cond_o    (cond),
    .set_word_o(word)
  );

  function automatic logic ref_cond(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic [3:0] s);
    logic lt, eq;
    eq = (a == b);
    lt = s[3] ? (a < b) : ($signed(a) < $signed(b));
    case (s[2:0])
      3'd0: return eq;
      3'd1: return !eq;
      3'd2: return lt;
      3'd3: return !lt;
      3'd4: return lt || eq;
      3'd5: return !lt && !eq;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s[2:0])
      3'd0: return "R2";
      3'd1, 3'd3: return "R7";
      3'd2: return s[3] ? "R4" : "R3";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check_one(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [3:0] s);
    logic exp_c;
    @(negedge clk);
    opa = a; opb = b; sel = s;
    #2;
    exp_c = ref_cond(a, b, s);
    checks++;
    if (cond !== exp_c) begin
      errors++;
      $display("FAIL %s (R1 mode %0d) a=%h b=%h sel=%h cond actual=%b expected=%b",
               req_of(s), s[3], a, b, s, cond, exp_c);
    end
    checks++;
    if (word !== {{(W-1){1'b0}}, exp_c}) begin
      errors++;
      $display("FAIL R9 a=%h b=%h sel=%h word actual=%h expected=%h",
               a, b, s, word, {{(W-1){1'b0}}, exp_c});
    end
  endtask

  initial begin : watchdog
    #(20 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] corners [6];
    logic [W-1:0] w0, w1;
    void'($urandom(32'd20240517));
    corners[0] = 32'h0000_0000;
    corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h8000_0000;
    corners[5] = 32'h8000_0001;
    opa = '0; opb = '0; sel = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R10: first settled state is already the combinational answer (0 == 0)
    check_one(32'h0, 32'h0, 4'h0);
    // R3 signed overflow pair, directed
    check_one(32'h8000_0000, 32'h0000_0001, 4'h2);
    check_one(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'h5);
    // R4 unsigned view of the same pair
    check_one(32'h8000_0000, 32'h0000_0001, 4'hA);
    // R1 R5 R6 R7 R8: every corner pair under every select code
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int s = 0; s < 16; s++)
          check_one(corners[i], corners[j], 4'(s));
    // R10 seeded random, including near-equal and equal operand pairs
    for (int n = 0; n < NRAND; n++) begin
      w0 = $urandom;
      case ($urandom % 4)
        0: w1 = w0;
        1: w1 = w0 + 32'd1;
        2: w1 = w0 ^ 32'h8000_0000;
        default: w1 = $urandom;
      endcase
      check_one(w0, w1, 4'($urandom % 16));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule